// File: doc/BRIEF.md
# DMA Channel Unbind Sequencer

This block runs one receive and one transmit DMA channel, each tied to an endpoint of a USB device controller. The CPU selects an endpoint for a channel by writing a non-zero number into that channel's endpoint field. It releases the channel by writing zero. The block also gates the DMA request of each direction so that only one request is outstanding at a time. It raises the end-of-transfer and transmit-complete interrupt strobes.

A zero write does not always release the channel on the next cycle. If a request is still in flight, or the transmit side still holds data, the channel stays tied to its old endpoint. The read-back field keeps showing the old number until the last buffer has been read, or until the last buffer has gone out in an IN transaction. Firmware polls that field and waits for zero. While the transmit side drains, its completion interrupt is withheld. An isochronous channel is released as soon as its open request has been serviced. A per-direction route code then tells the rest of the controller where later transactions to the endpoint are handled.

Top module: `dma_unbind_seq`

## Requirements
- R1: After reset, both endpoint read-backs are 0. Both DMA requests and both interrupt strobes are low. Both route codes read 2'b01.
- R2: A DMA request that is serviced by its acknowledge input is low in the following cycle, even if work is still waiting. Each direction has at most one request outstanding.
- R3: A DMA request rises one cycle after its raise condition holds on a bound channel. For RX the condition is that fill bit 0 (buffer A) or fill bit 1 (buffer B) is set. For non-isochronous TX the condition is a free buffer: buffer A empty in single mode, or not both buffers full in double mode.
- R4: On an isochronous TX channel, a request rises only in the cycle after a start-of-frame strobe. It then stays high until it is serviced.
- R5: Writing 0 to the RX endpoint while no RX request is high clears the read-back after that clock edge.
- R6: Writing 0 to the RX endpoint while an RX request is high keeps the old read-back until that request is serviced. In double mode with both buffers non-empty at the write, the read-back is held until two requests have been serviced.
- R7: eot_irq is high for exactly the cycle after an rx_eot strobe that arrives while the RX channel is bound, including while it is draining. It stays low when the channel is unbound.
- R8: Writing 0 to the TX endpoint while a non-isochronous TX request is high keeps the old read-back until that request is serviced and the TX fill state returns to 2'b00. No TX_DONE pulse occurs meanwhile, even when an IN transaction completes with a zero count.
- R9: Writing 0 to the TX endpoint with no TX request high clears the read-back once the TX fill state is 2'b00. This happens at once if the buffers are already empty. No TX_DONE pulse occurs during the drain.
- R10: tx_done_irq pulses in the cycle after an IN completion with zero count on a bound, non-draining TX channel. If that pulse has not been acknowledged when 0 is written, the read-back is held until tx_done_ack.
- R11: For an isochronous endpoint in either direction, a zero write made while a request is high releases the channel on the edge that services that request. It does not wait for buffers to drain.
- R12: Any endpoint write made while a release is pending is ignored. The read-back keeps the old number, and it returns to 0 rather than to the newly written value.
- R13: The route code of a direction is 2'b00 while its read-back is non-zero. When the read-back is zero, the code is 2'b01 for a non-isochronous endpoint and 2'b10 for an isochronous endpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_cfg_wr | input | 1 | CPU write strobe for the RX endpoint field |
| rx_cfg_ep | input | EP_W | Endpoint value written for RX (0 releases) |
| rx_fill | input | 2 | RX buffer non-empty flags, bit 0 buffer A, bit 1 buffer B |
| rx_dbl | input | 1 | RX double-buffer mode |
| rx_iso | input | 1 | RX endpoint is isochronous |
| rx_rd_ack | input | 1 | DMA has read the buffer of the open RX request |
| rx_eot | input | 1 | End-of-transfer strobe from the core |
| tx_cfg_wr | input | 1 | CPU write strobe for the TX endpoint field |
| tx_cfg_ep | input | EP_W | Endpoint value written for TX (0 releases) |
| tx_fill | input | 2 | TX buffer full flags, bit 0 buffer A, bit 1 buffer B |
| tx_dbl | input | 1 | TX double-buffer mode |
| tx_iso | input | 1 | TX endpoint is isochronous |
| tx_wr_ack | input | 1 | DMA has written the buffer of the open TX request |
| tx_in_done | input | 1 | An IN transaction has completed |
| tx_count_zero | input | 1 | Transfer size count is zero |
| tx_done_ack | input | 1 | CPU has handled the TX_DONE interrupt |
| tx_sof | input | 1 | Start-of-frame strobe |
| rx_dma_req | output | 1 | RX DMA request |
| tx_dma_req | output | 1 | TX DMA request |
| eot_irq | output | 1 | End-of-transfer interrupt pulse |
| tx_done_irq | output | 1 | Transmit-complete interrupt pulse |
| rx_ep_rd | output | EP_W | Effective RX endpoint read-back |
| tx_ep_rd | output | EP_W | Effective TX endpoint read-back |
| rx_route | output | 2 | RX transaction route code |
| tx_route | output | 2 | TX transaction route code |

## Verification
The bench builds the block with EP_W = 4. This allows endpoint numbers up to 15, so a value written during a pending release (7 or 5) is always distinct from both the held value and zero. The bench drives the fill flags, acknowledges and strobes cycle by cycle. This covers single and double buffering, both isochronous release paths, a release held by an unacknowledged completion interrupt, and strobes that arrive while a drain is in progress.

// File: rtl/dus_pkg.sv
// Shared types of the DMA unbind sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package dus_pkg;

    // Route code of one direction (fixed encoding, visible at the ports).
    typedef enum logic [1:0] {
        ROUTE_DMA   = 2'b00,
        ROUTE_EPIRQ = 2'b01,
        ROUTE_SOF   = 2'b10
    } route_e;

    // Release progress of the transmit channel.
    typedef enum logic [1:0] {
        TXU_IDLE  = 2'b00,
        TXU_WREQ  = 2'b01,
        TXU_DRAIN = 2'b10,
        TXU_WACK  = 2'b11
    } txu_e;

endpackage

// File: rtl/dus_route.sv
// Route encoder: tells where transactions of one direction are handled.
// A bound channel keeps them on DMA. An unbound one sends them to the
// endpoint interrupt, or to the start-of-frame handler when isochronous.
// Assumes: ep is the effective (registered) endpoint number.
module dus_route
    import dus_pkg::*;
#(
    parameter int EP_W = 4
) (
    input  logic [EP_W-1:0] ep,
    input  logic            iso,
    output logic [1:0]      route
);

    // Pick the route code from binding state and endpoint type.
    always_comb begin
        if (ep != '0)
            route = ROUTE_DMA;
        else if (iso)
            route = ROUTE_SOF;
        else
            route = ROUTE_EPIRQ;
    end

endmodule

// File: rtl/dus_rx_chan.sv
// Receive channel: request gating, end-of-transfer pulse, deferred release.
// A zero write with an open request keeps the endpoint until one (or two, for
// double buffering with both buffers full) requests have been serviced.
// Assumes: rd_ack only arrives while dma_req is high; eot is a strobe.
module dus_rx_chan #(
    parameter int EP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [EP_W-1:0] cfg_ep,
    input  logic [1:0]      fill,
    input  logic            dbl,
    input  logic            iso,
    input  logic            rd_ack,
    input  logic            eot,
    output logic            dma_req,
    output logic            eot_irq,
    output logic [EP_W-1:0] ep_rd
);

    localparam logic [1:0] ONE = 2'd1;
    localparam logic [1:0] TWO = 2'd2;

    logic [EP_W-1:0] ep_q, ep_d;
    logic            req_q, req_d;
    logic            pend_q, pend_d;
    logic [1:0]      left_q, left_d;
    logic            eot_q;
    logic            bound, unsel, sel;
    logic [1:0]      need;

    // Next-state logic for binding, pending release and request.
    always_comb begin
        bound  = (ep_q != '0);
        unsel  = cfg_wr && (cfg_ep == '0) && bound && !pend_q;
        sel    = cfg_wr && (cfg_ep != '0) && !pend_q;
        need   = (!iso && dbl && (fill == 2'b11)) ? TWO : ONE;
        ep_d   = ep_q;
        pend_d = pend_q;
        left_d = left_q;
        if (sel) begin
            ep_d = cfg_ep;
        end else if (unsel) begin
            if (!req_q || (rd_ack && need == ONE)) begin
                ep_d = '0;
            end else begin
                pend_d = 1'b1;
                left_d = rd_ack ? (need - ONE) : need;
            end
        end else if (pend_q && rd_ack) begin
            if (left_q == ONE) begin
                ep_d   = '0;
                pend_d = 1'b0;
            end else begin
                left_d = left_q - ONE;
            end
        end
        req_d = req_q;
        if (req_q && rd_ack)
            req_d = 1'b0;
        else if (!req_q && bound && (fill != 2'b00) && !unsel)
            req_d = 1'b1;
        if (ep_d == '0)
            req_d = 1'b0;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ep_q   <= '0;
            req_q  <= 1'b0;
            pend_q <= 1'b0;
            left_q <= '0;
            eot_q  <= 1'b0;
        end else begin
            ep_q   <= ep_d;
            req_q  <= req_d;
            pend_q <= pend_d;
            left_q <= left_d;
            eot_q  <= eot && bound;
        end
    end

    assign dma_req = req_q;
    assign eot_irq = eot_q;
    assign ep_rd   = ep_q;

endmodule

// File: rtl/dus_tx_chan.sv
// Transmit channel: request gating (buffer space or start-of-frame), the
// completion interrupt, and release after service, drain or interrupt
// handling. The completion pulse is withheld while a release is pending.
// Assumes: wr_ack only arrives while dma_req is high; strobes last one cycle.
module dus_tx_chan
    import dus_pkg::*;
#(
    parameter int EP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [EP_W-1:0] cfg_ep,
    input  logic [1:0]      fill,
    input  logic            dbl,
    input  logic            iso,
    input  logic            wr_ack,
    input  logic            in_done,
    input  logic            cnt_zero,
    input  logic            done_ack,
    input  logic            sof,
    output logic            dma_req,
    output logic            done_irq,
    output logic [EP_W-1:0] ep_rd
);

    logic [EP_W-1:0] ep_q, ep_d;
    logic            req_q, req_d;
    txu_e            st_q, st_d;
    logic            dout_q, dout_d;
    logic            done_q;
    logic            bound, pend, unsel, sel, free_buf, want, fire;

    // Decode of request, completion and release conditions.
    always_comb begin
        bound    = (ep_q != '0);
        pend     = (st_q != TXU_IDLE);
        unsel    = cfg_wr && (cfg_ep == '0) && bound && !pend;
        sel      = cfg_wr && (cfg_ep != '0) && !pend;
        free_buf = dbl ? (fill != 2'b11) : !fill[0];
        want     = iso ? sof : free_buf;
        fire     = bound && !pend && !unsel && in_done && cnt_zero;
    end

    // Next-state logic of the release sequence.
    always_comb begin
        ep_d = ep_q;
        st_d = st_q;
        unique case (st_q)
            TXU_IDLE: begin
                if (sel) begin
                    ep_d = cfg_ep;
                end else if (unsel) begin
                    if (dout_q && !done_ack)
                        st_d = TXU_WACK;
                    else if (req_q && !wr_ack)
                        st_d = TXU_WREQ;
                    else if (iso || (!req_q && fill == 2'b00))
                        ep_d = '0;
                    else
                        st_d = TXU_DRAIN;
                end
            end
            TXU_WREQ: begin
                if (wr_ack) begin
                    if (iso) begin
                        ep_d = '0;
                        st_d = TXU_IDLE;
                    end else begin
                        st_d = TXU_DRAIN;
                    end
                end
            end
            TXU_DRAIN: begin
                if (fill == 2'b00) begin
                    ep_d = '0;
                    st_d = TXU_IDLE;
                end
            end
            TXU_WACK: begin
                if (done_ack) begin
                    ep_d = '0;
                    st_d = TXU_IDLE;
                end
            end
            default: st_d = TXU_IDLE;
        endcase
    end

    // Next-state logic of request and outstanding-interrupt flag.
    always_comb begin
        req_d = req_q;
        if (req_q && wr_ack)
            req_d = 1'b0;
        else if (!req_q && bound && !pend && !unsel && want)
            req_d = 1'b1;
        if (ep_d == '0)
            req_d = 1'b0;
        dout_d = dout_q;
        if (done_ack)
            dout_d = 1'b0;
        else if (fire)
            dout_d = 1'b1;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ep_q   <= '0;
            req_q  <= 1'b0;
            st_q   <= TXU_IDLE;
            dout_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            ep_q   <= ep_d;
            req_q  <= req_d;
            st_q   <= st_d;
            dout_q <= dout_d;
            done_q <= fire;
        end
    end

    assign dma_req  = req_q;
    assign done_irq = done_q;
    assign ep_rd    = ep_q;

endmodule

// File: rtl/dma_unbind_seq.sv
// Top of the DMA unbind sequencer: one receive and one transmit channel plus
// a route encoder per direction (built by a generate loop).
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module dma_unbind_seq
    import dus_pkg::*;
#(
    parameter int EP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_cfg_wr,
    input  logic [EP_W-1:0] rx_cfg_ep,
    input  logic [1:0]      rx_fill,
    input  logic            rx_dbl,
    input  logic            rx_iso,
    input  logic            rx_rd_ack,
    input  logic            rx_eot,
    input  logic            tx_cfg_wr,
    input  logic [EP_W-1:0] tx_cfg_ep,
    input  logic [1:0]      tx_fill,
    input  logic            tx_dbl,
    input  logic            tx_iso,
    input  logic            tx_wr_ack,
    input  logic            tx_in_done,
    input  logic            tx_count_zero,
    input  logic            tx_done_ack,
    input  logic            tx_sof,
    output logic            rx_dma_req,
    output logic            tx_dma_req,
    output logic            eot_irq,
    output logic            tx_done_irq,
    output logic [EP_W-1:0] rx_ep_rd,
    output logic [EP_W-1:0] tx_ep_rd,
    output logic [1:0]      rx_route,
    output logic [1:0]      tx_route
);

    localparam int NDIR = 2;

    logic [NDIR-1:0][EP_W-1:0] ep_v;
    logic [NDIR-1:0]           iso_v;
    logic [NDIR-1:0][1:0]      route_v;

    dus_rx_chan #(.EP_W(EP_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (rx_cfg_wr),
        .cfg_ep  (rx_cfg_ep),
        .fill    (rx_fill),
        .dbl     (rx_dbl),
        .iso     (rx_iso),
        .rd_ack  (rx_rd_ack),
        .eot     (rx_eot),
        .dma_req (rx_dma_req),
        .eot_irq (eot_irq),
        .ep_rd   (rx_ep_rd)
    );

    dus_tx_chan #(.EP_W(EP_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (tx_cfg_wr),
        .cfg_ep   (tx_cfg_ep),
        .fill     (tx_fill),
        .dbl      (tx_dbl),
        .iso      (tx_iso),
        .wr_ack   (tx_wr_ack),
        .in_done  (tx_in_done),
        .cnt_zero (tx_count_zero),
        .done_ack (tx_done_ack),
        .sof      (tx_sof),
        .dma_req  (tx_dma_req),
        .done_irq (tx_done_irq),
        .ep_rd    (tx_ep_rd)
    );

    // Gather per-direction state for the route encoders (index 0 RX, 1 TX).
    assign ep_v[0]  = rx_ep_rd;
    assign ep_v[1]  = tx_ep_rd;
    assign iso_v[0] = rx_iso;
    assign iso_v[1] = tx_iso;

    for (genvar d = 0; d < NDIR; d++) begin : g_route
        dus_route #(.EP_W(EP_W)) u_route (
            .ep    (ep_v[d]),
            .iso   (iso_v[d]),
            .route (route_v[d])
        );
    end

    assign rx_route = route_v[0];
    assign tx_route = route_v[1];

endmodule

// File: rtl/dma_unbind_seq_chk.sv
// Temporal checks on the sequencer ports, attached to every instance by bind.
// Assumes: stimulus keeps strobes to one cycle and acknowledges only open requests.
module dma_unbind_seq_chk #(
    parameter int EP_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rx_cfg_wr,
    input logic            rx_rd_ack,
    input logic            rx_eot,
    input logic            tx_cfg_wr,
    input logic [1:0]      tx_fill,
    input logic            tx_iso,
    input logic            tx_wr_ack,
    input logic            tx_in_done,
    input logic            tx_count_zero,
    input logic            tx_done_ack,
    input logic            tx_sof,
    input logic            rx_dma_req,
    input logic            tx_dma_req,
    input logic            eot_irq,
    input logic            tx_done_irq,
    input logic [EP_W-1:0] rx_ep_rd,
    input logic [EP_W-1:0] tx_ep_rd
);

    p_rx_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dma_req && rx_rd_ack) |=> !rx_dma_req);

    p_tx_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dma_req && tx_wr_ack) |=> !tx_dma_req);

    p_rx_req_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dma_req) |-> $past(rx_ep_rd != '0));

    p_tx_iso_sof_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_dma_req) && tx_iso && $past(tx_iso)) |-> $past(tx_sof));

    p_rx_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_ep_rd != '0) |-> $past(rx_cfg_wr || rx_rd_ack));

    p_eot_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eot_irq |-> $past(rx_eot && (rx_ep_rd != '0)));

    p_tx_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ep_rd != '0) |-> $past(tx_cfg_wr || tx_wr_ack || tx_done_ack || (tx_fill == 2'b00)));

    p_done_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_irq |-> $past(tx_in_done && tx_count_zero && (tx_ep_rd != '0)));

endmodule

bind dma_unbind_seq dma_unbind_seq_chk #(.EP_W(EP_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_cfg_wr     (rx_cfg_wr),
    .rx_rd_ack     (rx_rd_ack),
    .rx_eot        (rx_eot),
    .tx_cfg_wr     (tx_cfg_wr),
    .tx_fill       (tx_fill),
    .tx_iso        (tx_iso),
    .tx_wr_ack     (tx_wr_ack),
    .tx_in_done    (tx_in_done),
    .tx_count_zero (tx_count_zero),
    .tx_done_ack   (tx_done_ack),
    .tx_sof        (tx_sof),
    .rx_dma_req    (rx_dma_req),
    .tx_dma_req    (tx_dma_req),
    .eot_irq       (eot_irq),
    .tx_done_irq   (tx_done_irq),
    .rx_ep_rd      (rx_ep_rd),
    .tx_ep_rd      (tx_ep_rd)
);

// File: tb/sim_dma_unbind_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the stimulus pushes expectations for the next clock edge;
// a monitor pops and compares them just after that edge.
module sim_dma_unbind_seq;

    localparam int EP_W = 4;
    localparam int S_RXEP = 0, S_TXEP = 1, S_RXREQ = 2, S_TXREQ = 3;
    localparam int S_EOT = 4, S_DONE = 5, S_RXRT = 6, S_TXRT = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_cfg_wr = 0, rx_dbl = 0, rx_iso = 0, rx_rd_ack = 0, rx_eot = 0;
    logic [EP_W-1:0] rx_cfg_ep = '0, tx_cfg_ep = '0;
    logic [1:0] rx_fill = 2'b00, tx_fill = 2'b00;
    logic tx_cfg_wr = 0, tx_dbl = 0, tx_iso = 0, tx_wr_ack = 0, tx_in_done = 0;
    logic tx_count_zero = 0, tx_done_ack = 0, tx_sof = 0;
    logic rx_dma_req, tx_dma_req, eot_irq, tx_done_irq;
    logic [EP_W-1:0] rx_ep_rd, tx_ep_rd;
    logic [1:0] rx_route, tx_route;

    int checks = 0, errors = 0;
    bit fin = 0;

    typedef struct { int sel; logic [7:0] exp; string tag; } sb_item_t;
    sb_item_t sb[$];

    always #2.5 clk = ~clk;

    dma_unbind_seq #(.EP_W(EP_W)) u0 (.*);

    function automatic logic [7:0] get_out(input int sel);
        case (sel)
            S_RXEP:  return 8'(rx_ep_rd);
            S_TXEP:  return 8'(tx_ep_rd);
            S_RXREQ: return 8'(rx_dma_req);
            S_TXREQ: return 8'(tx_dma_req);
            S_EOT:   return 8'(eot_irq);
            S_DONE:  return 8'(tx_done_irq);
            S_RXRT:  return 8'(rx_route);
            S_TXRT:  return 8'(tx_route);
            default: return 8'hff;
        endcase
    endfunction

    // Driver side: queue one expectation for the coming clock edge.
    task automatic expect_o(input int sel, input int val, input string tag);
        sb_item_t it;
        it.sel = sel; it.exp = 8'(val); it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // Monitor: compare queued expectations just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                sb_item_t it;
                logic [7:0] got;
                it = sb.pop_front();
                got = get_out(it.sel);
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s: output %0d got %0d expected %0d", it.tag, it.sel, got, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #1000000;
        if (!fin) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        expect_o(S_RXEP, 0, "R1"); expect_o(S_TXEP, 0, "R1");
        expect_o(S_RXREQ, 0, "R1"); expect_o(S_TXREQ, 0, "R1");
        expect_o(S_EOT, 0, "R1"); expect_o(S_DONE, 0, "R1");
        expect_o(S_RXRT, 1, "R1"); expect_o(S_TXRT, 1, "R1");

        // RX request gating
        cyc(); rx_cfg_wr = 1; rx_cfg_ep = 3; expect_o(S_RXEP, 3, "R3 bind"); expect_o(S_RXRT, 0, "R13");
        cyc(); rx_cfg_wr = 0; rx_fill = 2'b01; expect_o(S_RXREQ, 1, "R3");
        cyc(); rx_rd_ack = 1; expect_o(S_RXREQ, 0, "R2");
        cyc(); rx_rd_ack = 0; expect_o(S_RXREQ, 1, "R2");
        cyc(); rx_rd_ack = 1; rx_fill = 2'b00; expect_o(S_RXREQ, 0, "R2");
        cyc(); rx_rd_ack = 0; expect_o(S_RXREQ, 0, "R3");
        // R5 immediate release
        cyc(); rx_cfg_wr = 1; rx_cfg_ep = 0; expect_o(S_RXEP, 0, "R5"); expect_o(S_RXRT, 1, "R13");
        // R6 single buffer deferred release, R12 ignored write, R7 eot
        cyc(); rx_cfg_ep = 5; expect_o(S_RXEP, 5, "R6 bind");
        cyc(); rx_cfg_wr = 0; rx_fill = 2'b01; expect_o(S_RXREQ, 1, "R3");
        cyc(); rx_cfg_wr = 1; rx_cfg_ep = 0; expect_o(S_RXEP, 5, "R6"); expect_o(S_RXREQ, 1, "R6");
        cyc(); rx_cfg_ep = 7; expect_o(S_RXEP, 5, "R12");
        cyc(); rx_cfg_wr = 0; rx_eot = 1; expect_o(S_EOT, 1, "R7");
        cyc(); rx_eot = 0; rx_rd_ack = 1; rx_fill = 2'b00;
        expect_o(S_EOT, 0, "R7"); expect_o(S_RXEP, 0, "R6"); expect_o(S_RXREQ, 0, "R6");
        cyc(); rx_rd_ack = 0; expect_o(S_RXEP, 0, "R12");
        // R6 double buffer, both full
        cyc(); rx_dbl = 1; rx_cfg_wr = 1; rx_cfg_ep = 2; expect_o(S_RXEP, 2, "R6 bind");
        cyc(); rx_cfg_wr = 0; rx_fill = 2'b11; expect_o(S_RXREQ, 1, "R3");
        cyc(); rx_cfg_wr = 1; rx_cfg_ep = 0; expect_o(S_RXEP, 2, "R6");
        cyc(); rx_cfg_wr = 0; rx_rd_ack = 1; rx_fill = 2'b10;
        expect_o(S_RXEP, 2, "R6"); expect_o(S_RXREQ, 0, "R2");
        cyc(); rx_rd_ack = 0; expect_o(S_RXREQ, 1, "R6");
        cyc(); rx_rd_ack = 1; rx_fill = 2'b00; expect_o(S_RXEP, 0, "R6"); expect_o(S_RXREQ, 0, "R6");
        cyc(); rx_rd_ack = 0; rx_dbl = 0;
        // R7 eot while unbound
        cyc(); rx_eot = 1; expect_o(S_EOT, 0, "R7");
        cyc(); rx_eot = 0;
        // R11 RX isochronous
        cyc(); rx_iso = 1; rx_dbl = 1; rx_cfg_wr = 1; rx_cfg_ep = 4; expect_o(S_RXEP, 4, "R11 bind");
        cyc(); rx_cfg_wr = 0; rx_fill = 2'b11; expect_o(S_RXREQ, 1, "R3");
        cyc(); rx_cfg_wr = 1; rx_cfg_ep = 0; expect_o(S_RXEP, 4, "R11");
        cyc(); rx_cfg_wr = 0; rx_rd_ack = 1; rx_fill = 2'b10;
        expect_o(S_RXEP, 0, "R11"); expect_o(S_RXRT, 2, "R13");
        cyc(); rx_rd_ack = 0; rx_fill = 2'b00; expect_o(S_RXREQ, 0, "R11");
        cyc(); rx_iso = 0; rx_dbl = 0;

        // TX request gating
        cyc(); tx_cfg_wr = 1; tx_cfg_ep = 6; expect_o(S_TXEP, 6, "R3 bind");
        cyc(); tx_cfg_wr = 0; expect_o(S_TXREQ, 1, "R3");
        cyc(); tx_wr_ack = 1; tx_fill = 2'b01; expect_o(S_TXREQ, 0, "R2");
        cyc(); tx_wr_ack = 0; expect_o(S_TXREQ, 0, "R3");
        // R10 completion pulse, release waits for its handling
        cyc(); tx_in_done = 1; tx_count_zero = 1; tx_fill = 2'b00;
        expect_o(S_DONE, 1, "R10"); expect_o(S_TXREQ, 1, "R3");
        cyc(); tx_in_done = 0; tx_count_zero = 0; expect_o(S_DONE, 0, "R10");
        cyc(); tx_cfg_wr = 1; tx_cfg_ep = 0; expect_o(S_TXEP, 6, "R10");
        cyc(); tx_cfg_wr = 0; expect_o(S_TXEP, 6, "R10");
        cyc(); tx_done_ack = 1; expect_o(S_TXEP, 0, "R10"); expect_o(S_TXREQ, 0, "R10");
        expect_o(S_TXRT, 1, "R13");
        cyc(); tx_done_ack = 0;
        // R8 release with open request
        cyc(); tx_cfg_wr = 1; tx_cfg_ep = 9; expect_o(S_TXEP, 9, "R8 bind");
        cyc(); tx_cfg_wr = 0; expect_o(S_TXREQ, 1, "R3");
        cyc(); tx_cfg_wr = 1; tx_cfg_ep = 0; expect_o(S_TXEP, 9, "R8"); expect_o(S_TXREQ, 1, "R8");
        cyc(); tx_cfg_wr = 0; tx_in_done = 1; tx_count_zero = 1; expect_o(S_DONE, 0, "R8");
        cyc(); tx_in_done = 0; tx_count_zero = 0; tx_wr_ack = 1; tx_fill = 2'b01;
        expect_o(S_TXEP, 9, "R8"); expect_o(S_TXREQ, 0, "R8");
        cyc(); tx_wr_ack = 0; expect_o(S_TXEP, 9, "R8"); expect_o(S_TXREQ, 0, "R8");
        cyc(); tx_in_done = 1; tx_count_zero = 1; tx_fill = 2'b00;
        expect_o(S_TXEP, 0, "R8"); expect_o(S_DONE, 0, "R8");
        cyc(); tx_in_done = 0; tx_count_zero = 0;
        // R9 drain without request, R12 ignored write
        cyc(); tx_dbl = 1; tx_fill = 2'b11; tx_cfg_wr = 1; tx_cfg_ep = 1; expect_o(S_TXEP, 1, "R9 bind");
        cyc(); tx_cfg_wr = 0; expect_o(S_TXREQ, 0, "R3");
        cyc(); tx_cfg_wr = 1; tx_cfg_ep = 0; expect_o(S_TXEP, 1, "R9");
        cyc(); tx_cfg_ep = 5; tx_fill = 2'b10; tx_in_done = 1;
        expect_o(S_TXEP, 1, "R12"); expect_o(S_DONE, 0, "R9");
        cyc(); tx_cfg_wr = 0; tx_fill = 2'b00; tx_count_zero = 1;
        expect_o(S_TXEP, 0, "R9"); expect_o(S_DONE, 0, "R9");
        cyc(); tx_in_done = 0; tx_count_zero = 0; expect_o(S_TXEP, 0, "R12");
        cyc(); tx_cfg_wr = 1; tx_cfg_ep = 8; expect_o(S_TXEP, 8, "R9 bind");
        cyc(); tx_cfg_ep = 0; expect_o(S_TXEP, 0, "R9"); expect_o(S_TXREQ, 0, "R9");
        cyc(); tx_cfg_wr = 0; tx_dbl = 0;
        // R4 isochronous TX and R11 release
        cyc(); tx_iso = 1; tx_cfg_wr = 1; tx_cfg_ep = 10; expect_o(S_TXEP, 10, "R4 bind");
        cyc(); tx_cfg_wr = 0; expect_o(S_TXREQ, 0, "R4");
        cyc(); tx_sof = 1; expect_o(S_TXREQ, 1, "R4");
        cyc(); tx_sof = 0; expect_o(S_TXREQ, 1, "R4");
        cyc(); tx_wr_ack = 1; expect_o(S_TXREQ, 0, "R4");
        cyc(); tx_wr_ack = 0; expect_o(S_TXREQ, 0, "R4");
        cyc(); tx_sof = 1; expect_o(S_TXREQ, 1, "R4");
        cyc(); tx_sof = 0; tx_cfg_wr = 1; tx_cfg_ep = 0; tx_fill = 2'b01; expect_o(S_TXEP, 10, "R11");
        cyc(); tx_cfg_wr = 0; tx_wr_ack = 1;
        expect_o(S_TXEP, 0, "R11"); expect_o(S_TXREQ, 0, "R11"); expect_o(S_TXRT, 2, "R13");
        cyc(); tx_wr_ack = 0; tx_fill = 2'b00; tx_iso = 0; expect_o(S_TXRT, 1, "R13");

        cyc(); cyc();
        fin = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule